// File: doc/BRIEF.md
# Inter-Core Mailbox Register Bank

This block stores sixteen 32-bit message words, four belonging to each of four cores, for signalling between processors. A message word is never written directly. A writer raises bits by writing a mask to that word's set address, and the owning core lowers bits by writing a mask to the word's clear address. The owning core reads the word back at the same clear address. Each of the 32 bits in a word is an independent signal, so one word can carry up to 32 distinct events.

There are two independent write channels, so that two agents can reach the bank in the same cycle. A third channel handles reads and returns data one cycle after the request. A per-word pending flag is high while the word holds any set bit, and an external interrupt router uses these flags. Routing, enables and bus protocol conversion belong to other blocks.

Top module: `mbx_bank`

## Requirements
- R1: Synchronous active-low reset sets every word to zero, sets every pending flag low and sets `rd_data` to zero.
- R2: An aligned write of mask D to byte address 0x80 + 16n + 4m (core n, word m) ORs D into word 4n+m. Bits written as 0 keep their value.
- R3: An aligned write of mask D to byte address 0xC0 + 16n + 4m clears exactly the bits of word 4n+m that are 1 in D.
- R4: A read request at a clear address puts that word's contents on `rd_data` in the next cycle. The value returned is the one held before any write made in the same cycle. `rd_data` holds its value while no read is requested.
- R5: A read request at a set address, a misaligned address or an address below 0x80 returns zero.
- R6: `mbx_pending[4n+m]` is high exactly when word 4n+m is nonzero. It follows a write in the cycle after that write. A word that is set and then cleared in the next cycle shows its flag low immediately after the clear.
- R7: A set and a clear that reach the same word in one cycle produce (old & ~clear) | set, so the set wins on overlapping bits.
- R8: When both write channels target the same word in one cycle, their set masks combine by OR, and their clear masks combine by OR.
- R9: A write to a misaligned address (low two bits not zero) or to an address below 0x80 changes no word.
- R10: A write changes only the word it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_wr_en | input | 1 | Write strobe, channel A |
| a_wr_addr | input | 8 | Byte address, channel A |
| a_wr_data | input | 32 | Bit mask, channel A |
| b_wr_en | input | 1 | Write strobe, channel B |
| b_wr_addr | input | 8 | Byte address, channel B |
| b_wr_data | input | 32 | Bit mask, channel B |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| mbx_pending | output | 16 | Per-word nonzero flags, index 4n+m |

## Verification
The hardest situation to reach from the ports is a single cycle in which both channels hit one word, one setting and one clearing, with masks that overlap the bits already held. A read of that same word in the same cycle must still return the old value. Purely random addresses almost never land two channels on the same word. For that reason the random stimulus picks word indices from a small pool and combines sparse random masks, and directed cases force the overlap, set-then-clear on consecutive cycles, and writes to misaligned addresses.

// File: rtl/mbx_pkg.sv
// Shared types for the mailbox bank: the result of decoding one address.
// Assumes at most 256 words, so the index field is eight bits wide.
package mbx_pkg;

    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_SET  = 2'd1,
        HIT_CLR  = 2'd2
    } mbx_hit_e;

    typedef struct packed {
        mbx_hit_e   kind;
        logic [7:0] idx;
    } mbx_hit_t;

endpackage

// File: rtl/mbx_addr_decode.sv
// Address decoder: sorts a byte address into the set window, the clear
// window or neither, and gives the word index. Assumes word-aligned
// windows of NUM_BOX*4 bytes each that do not overlap.
module mbx_addr_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_BOX  = 16,
    parameter int SET_BASE = 'h80,
    parameter int CLR_BASE = 'hC0
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output mbx_hit_t          hit
);
    localparam int REGION = NUM_BOX * 4;
    localparam logic [ADDR_W:0] SET_LO = (ADDR_W+1)'(SET_BASE);
    localparam logic [ADDR_W:0] SET_HI = (ADDR_W+1)'(SET_BASE + REGION);
    localparam logic [ADDR_W:0] CLR_LO = (ADDR_W+1)'(CLR_BASE);
    localparam logic [ADDR_W:0] CLR_HI = (ADDR_W+1)'(CLR_BASE + REGION);

    logic [ADDR_W:0] addr_x;
    logic            aligned;
    logic            in_set;
    logic            in_clr;
    logic [ADDR_W:0] set_off;
    logic [ADDR_W:0] clr_off;

    assign addr_x  = {1'b0, addr};
    assign aligned = (addr[1:0] == 2'b00);
    assign in_set  = en && aligned && (addr_x >= SET_LO) && (addr_x < SET_HI);
    assign in_clr  = en && aligned && (addr_x >= CLR_LO) && (addr_x < CLR_HI);
    assign set_off = (addr_x - SET_LO) >> 2;
    assign clr_off = (addr_x - CLR_LO) >> 2;

    // Choose the window and the word index.
    always_comb begin
        hit.kind = HIT_NONE;
        hit.idx  = '0;
        if (in_set) begin
            hit.kind = HIT_SET;
            hit.idx  = 8'(set_off);
        end else if (in_clr) begin
            hit.kind = HIT_CLR;
            hit.idx  = 8'(clr_off);
        end
    end

endmodule

// File: rtl/mbx_cell.sv
// One message word: registered contents changed only by a set mask and a
// clear mask. The set mask wins on bits present in both masks.
module mbx_cell #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_mask,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] value,
    output logic              nonzero
);
    // Update the contents, or zero them in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) value <= '0;
        else        value <= (value & ~clr_mask) | set_mask;
    end

    assign nonzero = |value;

endmodule

// File: rtl/mbx_read_mux.sv
// Read path: decodes the read address and registers the selected word.
// Any address outside the clear window reads as zero. The output holds
// its value while no read is requested.
module mbx_read_mux
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_BOX  = 16,
    parameter int SET_BASE = 'h80,
    parameter int CLR_BASE = 'hC0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic [NUM_BOX*DATA_W-1:0] words,
    output logic [DATA_W-1:0]         rd_data
);
    mbx_hit_t          rd_hit;
    logic [DATA_W-1:0] sel;

    mbx_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_BOX(NUM_BOX),
        .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
    ) u_rd_dec (
        .en  (rd_en),
        .addr(rd_addr),
        .hit (rd_hit)
    );

    // Select the addressed word; every other address gives zero.
    always_comb begin
        sel = '0;
        for (int b = 0; b < NUM_BOX; b++) begin
            if (rd_hit.kind == HIT_CLR && rd_hit.idx == 8'(b))
                sel = words[b*DATA_W +: DATA_W];
        end
    end

    // Register the read result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel;
    end

endmodule

// File: rtl/mbx_bank.sv
// Inter-core mailbox bank (top). Two write channels each decode their
// address into a set or clear hit. Hits on each word are merged by OR and
// applied in one cycle. One read channel returns contents with one cycle
// of latency. The pending flags come straight from the word registers.
module mbx_bank
    import mbx_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 32,
    parameter int NUM_CORES     = 4,
    parameter int BOX_PER_CORE  = 4,
    parameter int SET_BASE      = 'h80,
    parameter int CLR_BASE      = 'hC0
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                a_wr_en,
    input  logic [ADDR_W-1:0]                   a_wr_addr,
    input  logic [DATA_W-1:0]                   a_wr_data,
    input  logic                                b_wr_en,
    input  logic [ADDR_W-1:0]                   b_wr_addr,
    input  logic [DATA_W-1:0]                   b_wr_data,
    input  logic                                rd_en,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [DATA_W-1:0]                   rd_data,
    output logic [NUM_CORES*BOX_PER_CORE-1:0]   mbx_pending
);
    localparam int NUM_BOX = NUM_CORES * BOX_PER_CORE;
    localparam int NUM_WP  = 2;

    logic     [NUM_WP-1:0]               wp_en;
    logic     [NUM_WP-1:0][ADDR_W-1:0]   wp_addr;
    logic     [NUM_WP-1:0][DATA_W-1:0]   wp_data;
    mbx_hit_t [NUM_WP-1:0]               wp_hit;

    logic [NUM_BOX-1:0][DATA_W-1:0]      set_mask;
    logic [NUM_BOX-1:0][DATA_W-1:0]      clr_mask;
    logic [NUM_BOX*DATA_W-1:0]           words;

    assign wp_en[0]   = a_wr_en;
    assign wp_addr[0] = a_wr_addr;
    assign wp_data[0] = a_wr_data;
    assign wp_en[1]   = b_wr_en;
    assign wp_addr[1] = b_wr_addr;
    assign wp_data[1] = b_wr_data;

    for (genvar p = 0; p < NUM_WP; p++) begin : g_wdec
        mbx_addr_decode #(
            .ADDR_W(ADDR_W), .NUM_BOX(NUM_BOX),
            .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
        ) u_dec (
            .en  (wp_en[p]),
            .addr(wp_addr[p]),
            .hit (wp_hit[p])
        );
    end

    for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
        // Merge the masks that every write channel aims at this word.
        always_comb begin
            set_mask[b] = '0;
            clr_mask[b] = '0;
            for (int p = 0; p < NUM_WP; p++) begin
                if (wp_hit[p].idx == 8'(b)) begin
                    if (wp_hit[p].kind == HIT_SET) set_mask[b] = set_mask[b] | wp_data[p];
                    if (wp_hit[p].kind == HIT_CLR) clr_mask[b] = clr_mask[b] | wp_data[p];
                end
            end
        end

        mbx_cell #(.DATA_W(DATA_W)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_mask(set_mask[b]),
            .clr_mask(clr_mask[b]),
            .value   (words[b*DATA_W +: DATA_W]),
            .nonzero (mbx_pending[b])
        );
    end

    mbx_read_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BOX(NUM_BOX),
        .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
    ) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .words  (words),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/mbx_bank_chk.sv
// Port-level checker for mbx_bank, attached with bind. It assumes the
// same parameters as the bank it watches.
module mbx_bank_chk #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_BOX  = 16,
    parameter int CLR_BASE = 'hC0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                a_wr_en,
    input logic                b_wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [DATA_W-1:0]   rd_data,
    input logic [NUM_BOX-1:0]  mbx_pending
);
    logic rd_in_clr;
    assign rd_in_clr = (rd_addr[1:0] == 2'b00) &&
                       ({1'b0, rd_addr} >= (ADDR_W+1)'(CLR_BASE)) &&
                       ({1'b0, rd_addr} <  (ADDR_W+1)'(CLR_BASE + NUM_BOX*4));

    // R1: reset clears the flags and the read data.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (mbx_pending == '0 && rd_data == '0));

    // R6: a flag can only rise after a write in the cycle before.
    a_r6_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((mbx_pending & ~$past(mbx_pending)) != '0) |-> $past(a_wr_en || b_wr_en));

    // R9: with no writes, the flags do not move.
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_wr_en || b_wr_en) |=> $stable(mbx_pending));

    // R4: read data holds while no read is requested.
    a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R5: reads outside the clear window give zero.
    a_r5_rd_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_in_clr) |=> (rd_data == '0));

endmodule

bind mbx_bank mbx_bank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .NUM_BOX(NUM_CORES*BOX_PER_CORE), .CLR_BASE(CLR_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_wr_en    (a_wr_en),
    .b_wr_en    (b_wr_en),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .mbx_pending(mbx_pending)
);

// File: tb/tb_mbx_bank.sv
`timescale 1ns/1ps
module tb_mbx_bank;
    localparam int NB = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wr_en = 1'b0, b_wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  a_wr_addr = '0, b_wr_addr = '0, rd_addr = '0;
    logic [31:0] a_wr_data = '0, b_wr_data = '0;
    logic [31:0] rd_data;
    logic [15:0] mbx_pending;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [31:0] model [NB];
    logic [31:0] rd_exp = '0;

    always #2 clk = ~clk;

    mbx_bank dut (
        .clk(clk), .rst_n(rst_n),
        .a_wr_en(a_wr_en), .a_wr_addr(a_wr_addr), .a_wr_data(a_wr_data),
        .b_wr_en(b_wr_en), .b_wr_addr(b_wr_addr), .b_wr_data(b_wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .mbx_pending(mbx_pending)
    );

    // Word index for an address in the window starting at base, or -1.
    function automatic int box_of(input logic [7:0] addr, input int base);
        int a = int'(addr);
        if (addr[1:0] != 2'b00) return -1;
        if (a < base || a >= base + 64) return -1;
        return (a - base) / 4;
    endfunction

    function automatic logic [15:0] pend_of();
        logic [15:0] p = '0;
        for (int k = 0; k < NB; k++) p[k] = (model[k] != 0);
        return p;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update the model at the edge, check at the next negedge.
    task automatic step(input logic ae, input logic [7:0] aa, input logic [31:0] ad,
                        input logic be, input logic [7:0] ba, input logic [31:0] bd,
                        input logic re, input logic [7:0] ra, input string tag);
        logic [31:0] s [NB];
        logic [31:0] c [NB];
        int k;
        a_wr_en = ae; a_wr_addr = aa; a_wr_data = ad;
        b_wr_en = be; b_wr_addr = ba; b_wr_data = bd;
        rd_en = re; rd_addr = ra;
        if (re) begin
            k = box_of(ra, 'hC0);
            rd_exp = (k >= 0) ? model[k] : 32'h0;
        end
        for (int i = 0; i < NB; i++) begin s[i] = '0; c[i] = '0; end
        if (ae) begin
            k = box_of(aa, 'h80); if (k >= 0) s[k] = s[k] | ad;
            k = box_of(aa, 'hC0); if (k >= 0) c[k] = c[k] | ad;
        end
        if (be) begin
            k = box_of(ba, 'h80); if (k >= 0) s[k] = s[k] | bd;
            k = box_of(ba, 'hC0); if (k >= 0) c[k] = c[k] | bd;
        end
        @(posedge clk);
        for (int i = 0; i < NB; i++) model[i] = (model[i] & ~c[i]) | s[i];
        @(negedge clk);
        a_wr_en = 1'b0; b_wr_en = 1'b0; rd_en = 1'b0;
        check({tag, " pending"}, {16'h0, mbx_pending}, {16'h0, pend_of()});
        check({tag, " rd_data"}, rd_data, rd_exp);
    endtask

    task automatic rd(input logic [7:0] ra, input string tag);
        step(1'b0, 8'h0, 32'h0, 1'b0, 8'h0, 32'h0, 1'b1, ra, tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NB; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 pending", {16'h0, mbx_pending}, 32'h0);
        check("R1 rd_data", rd_data, 32'h0);
        rst_n = 1'b1;
        rd(8'hC0, "R1 read word0");

        // R2: set core1 word2 at 0x98, then OR in more bits
        step(1'b1, 8'h98, 32'h0000_00F0, 1'b0, 8'h0, 32'h0, 1'b0, 8'h0, "R2 set");
        rd(8'hD8, "R2 R4 readback");
        step(1'b1, 8'h98, 32'h0000_000F, 1'b0, 8'h0, 32'h0, 1'b0, 8'h0, "R2 or");
        rd(8'hD8, "R2 readback or");
        // R3: clear exactly the ones
        step(1'b1, 8'hD8, 32'h0000_003C, 1'b0, 8'h0, 32'h0, 1'b0, 8'h0, "R3 clear");
        rd(8'hD8, "R3 readback");
        // R5: reads of set address and low address give zero
        rd(8'h98, "R5 set addr");
        rd(8'h10, "R5 low addr");
        rd(8'hD9, "R5 misaligned");
        // R7: set and clear same word, same cycle, with read of old value (R4)
        step(1'b1, 8'h98, 32'h0000_0101, 1'b1, 8'hD8, 32'h0000_01C3, 1'b1, 8'hD8, "R7 R4 overlap");
        rd(8'hD8, "R7 readback");
        // R8: both channels set, then both clear, word 15
        step(1'b1, 8'hBC, 32'hA000_0000, 1'b1, 8'hBC, 32'h0000_0005, 1'b0, 8'h0, "R8 dual set");
        rd(8'hFC, "R8 readback set");
        step(1'b1, 8'hFC, 32'hA000_0000, 1'b1, 8'hFC, 32'h0000_0004, 1'b0, 8'h0, "R8 dual clr");
        rd(8'hFC, "R8 readback clr");
        // R9: misaligned and low writes are ignored
        step(1'b1, 8'h81, 32'hFFFF_FFFF, 1'b1, 8'h40, 32'hFFFF_FFFF, 1'b0, 8'h0, "R9 ignored");
        rd(8'hC0, "R9 word0");
        rd(8'hC4, "R9 word1");
        // R6: set then clear next cycle, flag low at once; R10 others untouched
        step(1'b1, 8'h84, 32'h0000_0002, 1'b0, 8'h0, 32'h0, 1'b0, 8'h0, "R6 set");
        step(1'b1, 8'hC4, 32'h0000_0002, 1'b0, 8'h0, 32'h0, 1'b0, 8'h0, "R6 clr next");
        rd(8'hD8, "R10 neighbour");

        // Random phase: indices from a small pool to force collisions.
        for (int it = 0; it < 3000; it++) begin
            logic [7:0] aa, ba, ra;
            logic [31:0] ad, bd;
            aa = {1'b1, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 2'b00, 2'b00};
            ba = {1'b1, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 2'b00, 2'b00};
            ra = {1'b1, 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), 2'b00};
            if ($urandom_range(0, 15) == 0) aa = 8'($urandom);
            if ($urandom_range(0, 15) == 0) ra = 8'($urandom);
            ad = $urandom & $urandom & $urandom;
            bd = $urandom & $urandom;
            step(1'($urandom_range(0, 1)), aa, ad, 1'($urandom_range(0, 1)), ba, bd,
                 1'($urandom_range(0, 1)), ra, "R2 R3 R7 R8 random");
        end
        for (int k = 0; k < NB; k++) rd(8'(8'hC0 + 4 * k), "R4 R10 final sweep");
        finish_run();
    end
endmodule